// File: doc/BRIEF.md
# Four-Lane Justified Frame Demultiplexer

This block takes one serial bit stream carrying a higher-order frame and splits it into four lower-rate lane streams. The frame is already aligned upstream: a `frameStart` pulse marks its first bit. Each accepted bit arrives on `inBit` in a cycle where `inEn` is high. A frame is four sets of equal length, `SET_LEN` bits each, received in order. The usual lengths are 212 and 384. Any multiple of four that is at least 12 is accepted.

The first set starts with ten alignment bits, then one remote-alarm bit and one national bit. The rest of that set is payload. The other three sets each open with four justification control bits, one per lane. The last set also holds four stuffing positions right after its control bits. Payload is bit-interleaved across the lanes. For each lane, a two-of-three vote over its control bits decides whether that lane's stuffing position carries data or is discarded in the current frame. The alarm and national bits are republished once per frame. A per-lane flag shows when the vote had to overrule one disagreeing control bit.

Top module: `tribDemux`

## Requirements
- R1: Set 1 positions 1 to 12 are never delivered to any lane. Positions 1 to 10 are alignment, position 11 is the remote-alarm bit and position 12 is the national bit. Payload starts at position 13, on lane 0.
- R2: Every payload bit at 1-based position p of any set goes to lane (p-1) mod 4. Its value appears on `tribData[lane]`, with `tribValid` having only that lane's bit set. At most one lane is valid in any cycle.
- R3: Positions 1 to 4 of sets 2, 3 and 4 are control bits and are never delivered. Position n (1-based) belongs to lane n-1. The set number gives its vote row.
- R4: Positions 5 to 8 of set 4 are the stuffing positions of lanes 0 to 3. A lane's stuffing position is delivered as data when at most one of its three control bits is 1. It is dropped, with no valid strobe, when two or more are 1.
- R5: Each lane receives (SET_LEN-12)/4 + (SET_LEN-4)/2 + (SET_LEN-8)/4 valid bits per frame. One more is added when its stuffing position is delivered. For SET_LEN = 212 this is 205 or 206.
- R6: `raiBit` and `snBit` take the values of set 1 positions 11 and 12 together, in the cycle after position 12 is accepted. They hold at all other times, including after position 11 alone.
- R7: In the cycle after the last control bit (set 4, position 4) is accepted, `jcFix[l]` pulses for each lane l whose three control bits are not all equal. At all other times it is 0.
- R8: Every lane output is registered one cycle after the accepted bit. A cycle with `inEn` low produces no strobe and does not advance the frame position.
- R9: Before the first `frameStart`, input bits are ignored and no strobe appears. A `frameStart` with `inEn` always restarts decoding at set 1, position 1, even in the middle of a frame.
- R10: After reset, `tribValid`, `tribData`, `jcFix`, `raiBit` and `snBit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inEn | input | 1 | Bit on `inBit` is accepted this cycle |
| frameStart | input | 1 | Accepted bit is set 1, position 1 |
| inBit | input | 1 | Serial frame bit |
| tribData | output | 4 | Last delivered bit per lane |
| tribValid | output | 4 | Per-lane one-cycle strobe for a delivered bit |
| jcFix | output | 4 | Per-lane pulse: control vote was not unanimous |
| raiBit | output | 1 | Remote-alarm bit of the latest frame |
| snBit | output | 1 | National bit of the latest frame |

## Verification
There is exactly one register between an accepted input bit and each of its results. The lane strobe and data for a bit are due one cycle after it is accepted. The vote-correction pulse is due one cycle after the fourth control bit of set 4. The alarm and national pair are due one cycle after set 1 position 12. The bench drives a bit on a falling edge and records what that bit should produce. On the next falling edge it compares every output against that record, before it drives the next bit, so each check lands in the cycle where the result is due, including across idle cycles. Frames sweep all eight control-bit patterns on every lane, and a per-frame count of delivered bits is checked against the arithmetic formula.

// File: rtl/trib_demux_pkg.sv
package trib_demux_pkg;
  localparam int NUM_LANE   = 4;
  localparam int LANE_W     = 2;
  localparam int NUM_SET    = 4;
  localparam int SET_W      = 2;
  localparam int JC_ROWS    = NUM_SET - 1;
  localparam int RAI_POS    = 10;
  localparam int SN_POS     = 11;
  localparam int HDR_LEN    = 12;
  localparam int JC_LEN     = NUM_LANE;
  localparam int STUFF_END  = 2 * NUM_LANE;

  typedef struct packed {
    logic              active;
    logic              dataSlot;
    logic              stuffSlot;
    logic              jcSlot;
    logic              jcLast;
    logic              raiSlot;
    logic              snSlot;
    logic [LANE_W-1:0] lane;
    logic [SET_W-1:0]  jcRow;
  } slot_strobe_t;
endpackage

// File: rtl/tribDemuxCtrl.sv
module tribDemuxCtrl
  import trib_demux_pkg::*;
#(
  parameter int SET_LEN = 212
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inEn,
  input  logic         frameStart,
  output slot_strobe_t strb
);
  localparam int POS_W = $clog2(SET_LEN);
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(SET_LEN - 1);
  localparam logic [POS_W-1:0] RAI_P     = POS_W'(RAI_POS);
  localparam logic [POS_W-1:0] SN_P      = POS_W'(SN_POS);
  localparam logic [POS_W-1:0] HDR_P     = POS_W'(HDR_LEN);
  localparam logic [POS_W-1:0] JC_P      = POS_W'(JC_LEN);
  localparam logic [POS_W-1:0] STUFF_P   = POS_W'(STUFF_END);
  localparam logic [SET_W-1:0] FIRST_SET = '0;
  localparam logic [SET_W-1:0] LAST_SET  = SET_W'(NUM_SET - 1);

  logic [POS_W-1:0] bitCnt;
  logic [SET_W-1:0] setCnt;
  logic             locked;

  logic [POS_W-1:0] curPos;
  logic [SET_W-1:0] curSet;
  logic             active;
  logic             inFirst;
  logic             inLast;
  logic             inJcField;
  logic             inStuffField;

  always_comb begin
    curPos       = frameStart ? '0 : bitCnt;
    curSet       = frameStart ? FIRST_SET : setCnt;
    active       = inEn & (frameStart | locked);
    inFirst      = (curSet == FIRST_SET);
    inLast       = (curSet == LAST_SET);
    inJcField    = (curPos < JC_P);
    inStuffField = inLast & ~inJcField & (curPos < STUFF_P);
  end

  always_comb begin
    strb           = '0;
    strb.active    = active;
    strb.lane      = curPos[LANE_W-1:0];
    strb.jcRow     = SET_W'(curSet - SET_W'(1));
    if (active) begin
      if (inFirst) begin
        strb.raiSlot  = (curPos == RAI_P);
        strb.snSlot   = (curPos == SN_P);
        strb.dataSlot = (curPos >= HDR_P);
      end else begin
        strb.jcSlot    = inJcField;
        strb.jcLast    = inLast & (curPos == JC_P - POS_W'(1));
        strb.stuffSlot = inStuffField;
        strb.dataSlot  = ~inJcField & ~inStuffField;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      setCnt <= '0;
      locked <= 1'b0;
    end else if (active) begin
      locked <= 1'b1;
      if (curPos == LAST_POS) begin
        bitCnt <= '0;
        setCnt <= SET_W'(curSet + SET_W'(1));
      end else begin
        bitCnt <= curPos + POS_W'(1);
        setCnt <= curSet;
      end
    end
  end

  // R2: the position counter never leaves the set
  p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_POS);

  // R8: an idle cycle leaves the frame position untouched
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!inEn) |=> $stable({bitCnt, setCnt}));

  // R9: nothing is strobed before the first frame start
  p_prelock_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !frameStart) |-> !(strb.dataSlot || strb.stuffSlot || strb.jcSlot));
endmodule

// File: rtl/tribDemuxData.sv
module tribDemuxData
  import trib_demux_pkg::*;
#(
  parameter int SET_LEN = 212
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inBit,
  input  slot_strobe_t        strb,
  output logic [NUM_LANE-1:0] tribData,
  output logic [NUM_LANE-1:0] tribValid,
  output logic [NUM_LANE-1:0] jcFix,
  output logic                raiBit,
  output logic                snBit
);
  localparam int MIN_LEN = HDR_LEN;
  localparam bit LEN_OK  = (SET_LEN >= MIN_LEN) && (SET_LEN % NUM_LANE == 0);

  logic raiHold;

  generate
    if (!LEN_OK) begin : g_bad_len
      initial $display("tribDemuxData: SET_LEN must be a multiple of four and at least twelve");
    end
  endgenerate

  generate
    for (genvar l = 0; l < NUM_LANE; l++) begin : g_lane
      logic [JC_ROWS-1:0] jcCol;
      logic               lastVote;
      logic               voteA;
      logic               voteB;
      logic               voteC;
      logic               majority;
      logic               split;
      logic               laneHit;
      logic               take;
      logic               dropQ;
      logic               validQ;
      logic               dataQ;
      logic               fixQ;

      if (l == NUM_LANE - 1) begin : g_live
        assign lastVote = inBit;
      end else begin : g_held
        assign lastVote = jcCol[JC_ROWS-1];
      end

      always_comb begin
        voteA    = jcCol[0];
        voteB    = jcCol[1];
        voteC    = lastVote;
        majority = (voteA & voteB) | (voteA & voteC) | (voteB & voteC);
        split    = ~((voteA & voteB & voteC) | ~(voteA | voteB | voteC));
        laneHit  = (strb.lane == LANE_W'(l));
        take     = strb.active & laneHit &
                   (strb.dataSlot | (strb.stuffSlot & ~dropQ));
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          jcCol  <= '0;
          dropQ  <= 1'b0;
          validQ <= 1'b0;
          dataQ  <= 1'b0;
          fixQ   <= 1'b0;
        end else begin
          if (strb.jcSlot && laneHit) begin
            jcCol[strb.jcRow] <= inBit;
          end
          if (strb.jcLast) begin
            dropQ <= majority;
          end
          fixQ   <= strb.jcLast & split;
          validQ <= take;
          if (take) begin
            dataQ <= inBit;
          end
        end
      end

      assign tribValid[l] = validQ;
      assign tribData[l]  = dataQ;
      assign jcFix[l]     = fixQ;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      raiHold <= 1'b0;
      raiBit  <= 1'b0;
      snBit   <= 1'b0;
    end else begin
      if (strb.raiSlot) begin
        raiHold <= inBit;
      end
      if (strb.snSlot) begin
        raiBit <= raiHold;
        snBit  <= inBit;
      end
    end
  end

  // R2: at most one lane strobes per cycle
  p_one_lane_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tribValid));

  // R3: a control bit never becomes lane data
  p_jc_not_data_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.jcSlot |=> (tribValid == '0));

  // R1: header positions never become lane data
  p_hdr_not_data_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.raiSlot || strb.snSlot) |=> (tribValid == '0));

  // R8: no strobe follows an idle cycle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.active) |=> (tribValid == '0));

  // R6: alarm and national outputs move only after the national bit
  p_rs_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.snSlot) |=> $stable({raiBit, snBit}));

  // R7: the correction flag appears only after the last control bit
  p_fix_timing_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.jcLast) |=> (jcFix == '0));
endmodule

// File: rtl/tribDemux.sv
module tribDemux
  import trib_demux_pkg::*;
#(
  parameter int SET_LEN = 212
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inEn,
  input  logic                frameStart,
  input  logic                inBit,
  output logic [NUM_LANE-1:0] tribData,
  output logic [NUM_LANE-1:0] tribValid,
  output logic [NUM_LANE-1:0] jcFix,
  output logic                raiBit,
  output logic                snBit
);
  slot_strobe_t strb;

  tribDemuxCtrl #(.SET_LEN(SET_LEN)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inEn       (inEn),
    .frameStart (frameStart),
    .strb       (strb)
  );

  tribDemuxData #(.SET_LEN(SET_LEN)) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .inBit     (inBit),
    .strb      (strb),
    .tribData  (tribData),
    .tribValid (tribValid),
    .jcFix     (jcFix),
    .raiBit    (raiBit),
    .snBit     (snBit)
  );
endmodule

// File: tb/test_tribDemux.sv
module test_tribDemux;
  localparam int SETLEN = 212;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inEn = 1'b0;
  logic       frameStart = 1'b0;
  logic       inBit = 1'b0;
  logic [3:0] tribData;
  logic [3:0] tribValid;
  logic [3:0] jcFix;
  logic       raiBit;
  logic       snBit;

  tribDemux #(.SET_LEN(SETLEN)) i_tribDemux (
    .clk(clk), .rstN(rstN), .inEn(inEn), .frameStart(frameStart), .inBit(inBit),
    .tribData(tribData), .tribValid(tribValid), .jcFix(jcFix),
    .raiBit(raiBit), .snBit(snBit)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic       pendLive = 0;
  logic [3:0] pV, pD, pC;
  logic       pChk, pR, pS;
  string      pTag;
  int         laneCnt [4];
  int         genIdx [4];
  int         bitNum = 0;
  logic       prevRai = 0, prevSn = 0, newRai = 0;

  function automatic logic payload(int lane, int n);
    return 1'(((n ^ (n >> 2) ^ (n >> 3)) + lane) & 1);
  endfunction

  task automatic tick(input logic b, input logic fs, input logic en,
                      input logic [3:0] eV, input logic [3:0] eD, input logic [3:0] eC,
                      input logic chk, input logic eR, input logic eS, input string tag);
    @(negedge clk);
    if (pendLive) begin
      checks++;
      if (tribValid !== pV || (tribData & pV) !== (pD & pV) || jcFix !== pC) begin
        fails++;
        $display("FAIL %s: valid=%b data=%b fix=%b expected valid=%b data=%b fix=%b",
                 pTag, tribValid, tribData & pV, jcFix, pV, pD & pV, pC);
      end
      if (pChk) begin
        checks++;
        if (raiBit !== pR || snBit !== pS) begin
          fails++;
          $display("FAIL R6: rai=%b sn=%b expected rai=%b sn=%b", raiBit, snBit, pR, pS);
        end
      end
      for (int l = 0; l < 4; l++) if (tribValid[l] === 1'b1) laneCnt[l]++;
    end
    inBit = b; frameStart = fs; inEn = en;
    pV = eV; pD = eD; pC = eC; pChk = chk; pR = eR; pS = eS; pTag = tag;
    pendLive = 1;
  endtask

  task automatic idle(input string tag);
    tick(1'b1, 1'b0, 1'b0, 4'b0, 4'b0, 4'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // one frame (or its first 'limit' bits); jcPat[l] bit r = control bit of lane l in set r+2
  task automatic sendFrame(input logic [2:0] jcPat [4], input logic rai, input logic sn,
                           input int limit);
    logic [3:0] dropMask, corrMask;
    logic [9:0] fas;
    int sent;
    fas = 10'b1111010000;
    sent = 0;
    for (int l = 0; l < 4; l++) begin
      laneCnt[l] = 0;
      dropMask[l] = ($countones(jcPat[l]) >= 2);
      corrMask[l] = (jcPat[l] != 3'b000) && (jcPat[l] != 3'b111);
    end
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < SETLEN; p++) begin
        int lane;
        logic v;
        if (sent >= limit) break;
        lane = p % 4;
        bitNum++;
        if (bitNum % 37 == 36) idle("R8");
        if (s == 0 && p < 10)
          tick(fas[9-p], p == 0, 1'b1, 4'b0, 4'b0, 4'b0, 1'b0, 1'b0, 1'b0, "R1");
        else if (s == 0 && p == 10) begin
          newRai = rai;
          tick(rai, 1'b0, 1'b1, 4'b0, 4'b0, 4'b0, 1'b1, prevRai, prevSn, "R1");
        end else if (s == 0 && p == 11) begin
          prevRai = newRai; prevSn = sn;
          tick(sn, 1'b0, 1'b1, 4'b0, 4'b0, 4'b0, 1'b1, newRai, sn, "R1");
        end else if (s != 0 && p < 4) begin
          v = jcPat[p][s-1];
          if (s == 3 && p == 3)
            tick(v, 1'b0, 1'b1, 4'b0, 4'b0, corrMask, 1'b0, 1'b0, 1'b0, "R7");
          else
            tick(v, 1'b0, 1'b1, 4'b0, 4'b0, 4'b0, 1'b0, 1'b0, 1'b0, "R3");
        end else if (s == 3 && p < 8 && dropMask[lane]) begin
          v = ~payload(lane, genIdx[lane]);
          tick(v, 1'b0, 1'b1, 4'b0, 4'b0, 4'b0, 1'b0, 1'b0, 1'b0, "R4");
        end else begin
          v = payload(lane, genIdx[lane]);
          genIdx[lane]++;
          tick(v, 1'b0, 1'b1, 4'(1 << lane), {4{v}}, 4'b0, 1'b0, 1'b0, 1'b0,
               (s == 3 && p < 8) ? "R4" : "R2");
        end
        sent++;
      end
    end
    idle("R8");
    if (limit >= 4 * SETLEN) begin
      for (int l = 0; l < 4; l++) begin
        int expCnt;
        expCnt = (SETLEN - 12) / 4 + (SETLEN - 4) / 2 + (SETLEN - 8) / 4 + (dropMask[l] ? 0 : 1);
        checks++;
        if (laneCnt[l] != expCnt) begin
          fails++;
          $display("FAIL R5: lane %0d count=%0d expected %0d", l, laneCnt[l], expCnt);
        end
      end
    end
  endtask

  initial begin
    logic [2:0] pat [4];
    for (int l = 0; l < 4; l++) genIdx[l] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (tribValid !== 4'b0 || tribData !== 4'b0 || jcFix !== 4'b0 || raiBit !== 1'b0 || snBit !== 1'b0) begin
      fails++;
      $display("FAIL R10: valid=%b data=%b fix=%b rai=%b sn=%b expected all 0",
               tribValid, tribData, jcFix, raiBit, snBit);
    end
    // R9: bits before any frame start are ignored
    for (int i = 0; i < 40; i++)
      tick(1'(i % 3 == 0), 1'b0, 1'b1, 4'b0, 4'b0, 4'b0, 1'b0, 1'b0, 1'b0, "R9");
    // R9: a partial frame, then restart by a new frame start
    for (int l = 0; l < 4; l++) pat[l] = 3'(5 + l);
    sendFrame(pat, 1'b1, 1'b1, 300);
    for (int f = 0; f < 10; f++) begin
      for (int l = 0; l < 4; l++) pat[l] = 3'((f + 3 * l) % 8);
      sendFrame(pat, 1'(f % 2), 1'((f / 2) % 2), 4 * SETLEN);
    end
    idle("R8");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule